// File: doc/BRIEF.md
# Paged DMA Address Generator

This block keeps the memory pointer of one DMA channel and drives the 24-bit physical address for every transfer. It has two parts. An 8-bit page register supplies the upper address bits and changes only when software writes it. A 16-bit offset counter supplies the lower bits and steps once per transfer. Software loads the counter one byte at a time through a single byte-wide write port. A low/high pointer decides which half each write lands in, and a clear strobe sends that pointer back to the low half.

A mode input selects the bus mapping. In byte mode the counter covers the low 16 address bits, so the address steps by one and wraps inside a 64 KiB page. In word mode the counter is shifted up by one bit and bit 0 is held at zero, so the address steps by two, stays even, and wraps inside a 128 KiB page. In word mode the page supplies only its upper seven bits. When the counter overflows, the page stays fixed and the address falls back to the bottom of the same page. No error is raised.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the page register, the offset counter and the byte pointer are all zero, so `mem_addr` reads 0x000000.
- R2: A `page_wr` pulse loads `page_data` into the page register, and the new page shows on `mem_addr` in the next cycle. Nothing else changes the page.
- R3: Each `offs_wr` pulse writes `offs_data` to one counter half. Counter bits 7:0 take it when the pointer is low, bits 15:8 when it is high. The pointer toggles after every write and starts low after reset.
- R4: `ptr_clr` forces the pointer low. An `offs_wr` in the same cycle goes to bits 7:0 and leaves the pointer high.
- R5: With `word_mode` = 0, `mem_addr` is {page[7:0], counter[15:0]}.
- R6: With `word_mode` = 1, `mem_addr` is {page[7:1], counter[15:0], 1'b0}. Page bit 0 has no effect on the address.
- R7: In a cycle with `xfer_stb` high, `mem_addr` still shows the pre-increment value. The counter has gone up by one from the next cycle on.
- R8: A transfer at counter 0xFFFF wraps the counter to 0x0000 and leaves the page unchanged. The address drops 64 KiB in byte mode and 128 KiB in word mode.
- R9: When `offs_wr` and `xfer_stb` are high together, the byte write is applied and the counter is not incremented.
- R10: Changing `word_mode` changes only the mapping. The counter and page keep their values, and switching back restores the previous address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| page_wr | input | 1 | Load strobe for the page register |
| page_data | input | 8 | Page value to load |
| offs_wr | input | 1 | Byte write strobe for the offset counter |
| offs_data | input | 8 | Byte to write into the counter |
| ptr_clr | input | 1 | Returns the low/high byte pointer to low |
| word_mode | input | 1 | 0: byte mapping, 1: word mapping |
| xfer_stb | input | 1 | One pulse per completed transfer; advances the counter |
| mem_addr | output | 24 | Physical memory address |

## Verification
`mem_addr` is combinational from the stored state and from `word_mode`. A mode change therefore shows in the same cycle, while a page write, an offset byte write or a transfer strobe shows one clock edge later. The bench drives inputs on the falling edge. It compares the address 1 ns later against a model that still holds the state from before the coming edge, which confirms the pre-increment address during a strobe. It updates the model only at the rising edge. Directed checks taken after a write or strobe sample at the next falling edge, one edge after the stimulus.

// File: rtl/dma_addr_pkg.sv
// Package: shared widths and the address mapping mode type.
// Assumes the offset counter is exactly two host bytes wide.
package dma_addr_pkg;
    localparam int HOST_W = 8;            // width of the host write port
    localparam int PAGE_W = 8;            // page register width
    localparam int OFFS_W = 2 * HOST_W;   // offset counter width
    localparam int ADDR_W = PAGE_W + OFFS_W;

    typedef enum logic {
        MAP_BYTE = 1'b0,
        MAP_WORD = 1'b1
    } map_mode_e;
endpackage

// File: rtl/dma_byte_ptr.sv
// Module: low/high byte pointer for the two-write counter load.
// Assumes clear wins over the current state and a write in the same
// cycle sees the cleared (low) pointer.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr,
    output logic sel_hi
);
    logic eff_hi;

    // Pointer as seen by a write in this cycle.
    always_comb eff_hi = clr ? 1'b0 : sel_hi;

    // Advance the pointer after each byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_hi <= 1'b0;
        else if (wr)
            sel_hi <= ~eff_hi;
        else
            sel_hi <= eff_hi;
    end

    // R3: a write without clear flips the pointer.
    assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (sel_hi != $past(sel_hi)));
    // R4: a clear with a write leaves the pointer high.
    assert_clr_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && clr) |=> sel_hi);
endmodule

// File: rtl/dma_offs_counter.sv
// Module: offset counter loaded in byte halves, stepped once per transfer.
// Assumes a byte write takes priority over an increment in the same cycle.
module dma_offs_counter #(
    parameter int HOST_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  sel_hi,
    input  logic                  clr,
    input  logic [HOST_W-1:0]     data,
    input  logic                  inc,
    output logic [2*HOST_W-1:0]   cnt
);
    localparam int CNT_W = 2 * HOST_W;
    logic to_hi;

    // Half selected for this cycle's write.
    always_comb to_hi = sel_hi && !clr;

    // Load a half, or step by one with silent wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr && to_hi)
            cnt[CNT_W-1:HOST_W] <= data;
        else if (wr)
            cnt[HOST_W-1:0] <= data;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // R7: a lone transfer strobe raises the counter by one.
    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && !(&cnt)) |=> (cnt == $past(cnt) + 1'b1));
    // R8: the counter wraps to zero from all ones.
    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && (&cnt)) |=> (cnt == '0));
    // R9: a write in the same cycle blocks the increment.
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && wr && !to_hi) |=> (cnt[HOST_W-1:0] == $past(data)
                                   && cnt[CNT_W-1:HOST_W] == $past(cnt[CNT_W-1:HOST_W])));
endmodule

// File: rtl/dma_page_reg.sv
// Module: page register; it never counts.
// Assumes only an explicit write may change it.
module dma_page_reg #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PAGE_W-1:0] data,
    output logic [PAGE_W-1:0] page
);
    // Hold the page until software writes a new one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (wr)
            page <= data;
    end

    // R2: the page holds without a write.
    assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(page));
endmodule

// File: rtl/dma_addr_map.sv
// Module: places page and counter on the physical address bus.
// Assumes ADDR_W = PAGE_W + OFFS_W; in word mode page bit 0 is dropped.
module dma_addr_map
    import dma_addr_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFFS_W = 16
) (
    input  logic [PAGE_W-1:0]        page,
    input  logic [OFFS_W-1:0]        cnt,
    input  map_mode_e                mode,
    output logic [PAGE_W+OFFS_W-1:0] addr
);
    localparam int A_W = PAGE_W + OFFS_W;
    logic [A_W-1:0] byte_addr;
    logic [A_W-1:0] word_addr;

    // Byte layout: page above the counter.
    always_comb byte_addr = {page, cnt};
    // Word layout: counter shifted one bit up, bit 0 low.
    always_comb word_addr = {page[PAGE_W-1:1], cnt, 1'b0};
    // Pick the layout by mode.
    always_comb addr = (mode == MAP_WORD) ? word_addr : byte_addr;
endmodule

// File: rtl/dma_addr_gen.sv
// Module: top of the paged DMA address generator.
// Assumes strobes are single-cycle and synchronous to clk.
module dma_addr_gen
    import dma_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_wr,
    input  logic [PAGE_W-1:0] page_data,
    input  logic              offs_wr,
    input  logic [HOST_W-1:0] offs_data,
    input  logic              ptr_clr,
    input  logic              word_mode,
    input  logic              xfer_stb,
    output logic [ADDR_W-1:0] mem_addr
);
    logic              sel_hi;
    logic [OFFS_W-1:0] cnt;
    logic [PAGE_W-1:0] page;
    map_mode_e         mode;

    // Mode input as the enum type.
    always_comb mode = map_mode_e'(word_mode);

    dma_byte_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .wr(offs_wr), .sel_hi(sel_hi)
    );

    dma_offs_counter #(.HOST_W(HOST_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr(offs_wr), .sel_hi(sel_hi), .clr(ptr_clr),
        .data(offs_data), .inc(xfer_stb), .cnt(cnt)
    );

    dma_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk(clk), .rst_n(rst_n), .wr(page_wr), .data(page_data), .page(page)
    );

    dma_addr_map #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_map (
        .page(page), .cnt(cnt), .mode(mode), .addr(mem_addr)
    );

    // R8: a byte-mode wrap keeps the page bits on the bus.
    assert_wrap_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !offs_wr && !page_wr && !word_mode && (&cnt)) |=>
        (!word_mode |-> mem_addr[ADDR_W-1:OFFS_W] == $past(mem_addr[ADDR_W-1:OFFS_W])));
endmodule

// File: tb/dma_addr_gen_bench.sv
module dma_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_wr = 1'b0;
    logic [7:0]  page_data = '0;
    logic        offs_wr = 1'b0;
    logic [7:0]  offs_data = '0;
    logic        ptr_clr = 1'b0;
    logic        word_mode = 1'b0;
    logic        xfer_stb = 1'b0;
    logic [23:0] mem_addr;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    logic [7:0]  m_page;
    logic [15:0] m_cnt;
    logic        m_hi;

    always #5 clk = ~clk;

    dma_addr_gen u_dma_addr_gen (
        .clk(clk), .rst_n(rst_n), .page_wr(page_wr), .page_data(page_data),
        .offs_wr(offs_wr), .offs_data(offs_data), .ptr_clr(ptr_clr),
        .word_mode(word_mode), .xfer_stb(xfer_stb), .mem_addr(mem_addr)
    );

    function automatic logic [23:0] exp_addr(input logic [7:0] pg,
                                             input logic [15:0] c, input logic wm);
        return wm ? {pg[7:1], c, 1'b0} : {pg, c};
    endfunction

    task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: mem_addr=%06h expected %06h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check pre-edge address, update model.
    task automatic cyc(input logic pw, input logic [7:0] pd, input logic ow,
                       input logic [7:0] od, input logic clr, input logic wm,
                       input logic stb, input string req);
        logic eff;
        page_wr = pw; page_data = pd; offs_wr = ow; offs_data = od;
        ptr_clr = clr; word_mode = wm; xfer_stb = stb;
        #1;
        check(mem_addr, exp_addr(m_page, m_cnt, wm), req);
        @(posedge clk);
        eff = clr ? 1'b0 : m_hi;
        if (pw) m_page = pd;
        if (ow) begin
            if (eff) m_cnt[15:8] = od; else m_cnt[7:0] = od;
        end else if (stb) m_cnt = m_cnt + 16'd1;
        m_hi = ow ? ~eff : eff;
        #1;
        page_wr = 1'b0; offs_wr = 1'b0; ptr_clr = 1'b0; xfer_stb = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        m_page = '0; m_cnt = '0; m_hi = 1'b0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(mem_addr, 24'h000000, "R1");

        cyc(1, 8'h5A, 0, 0, 0, 0, 0, "R2");
        check(mem_addr, 24'h5A0000, "R2");
        cyc(0, 0, 1, 8'h34, 0, 0, 0, "R3");
        cyc(0, 0, 1, 8'h12, 0, 0, 0, "R3");
        check(mem_addr, 24'h5A1234, "R3");
        cyc(0, 0, 1, 8'h78, 0, 0, 0, "R3");
        cyc(0, 0, 1, 8'h56, 1, 0, 0, "R4");
        cyc(0, 0, 1, 8'h9A, 0, 0, 0, "R4");
        check(mem_addr, 24'h5A9A56, "R4");
        cyc(0, 0, 0, 0, 0, 0, 1, "R7");
        check(mem_addr, 24'h5A9A57, "R7");
        cyc(0, 0, 1, 8'hFF, 1, 0, 0, "R8");
        cyc(0, 0, 1, 8'hFF, 0, 0, 0, "R8");
        check(mem_addr, 24'h5AFFFF, "R5");
        cyc(0, 0, 0, 0, 0, 0, 1, "R8");
        check(mem_addr, 24'h5A0000, "R8");
        // word mode on odd page
        cyc(1, 8'h5B, 1, 8'hFF, 1, 1, 0, "R6");
        cyc(0, 0, 1, 8'hFF, 0, 1, 0, "R6");
        check(mem_addr, 24'h5BFFFE, "R6");
        cyc(1, 8'h5A, 0, 0, 0, 1, 0, "R6");
        check(mem_addr, 24'h5BFFFE, "R6");
        cyc(0, 0, 0, 0, 0, 1, 1, "R8");
        check(mem_addr, 24'h5A0000, "R8");
        // write and strobe together: write wins
        cyc(0, 0, 1, 8'h40, 1, 1, 1, "R9");
        check(mem_addr, 24'h5A0080, "R9");
        // mode switch leaves the state alone
        word_mode = 1'b0; #1;
        check(mem_addr, 24'h5A0040, "R10");
        word_mode = 1'b1; #1;
        check(mem_addr, 24'h5A0080, "R10");
        @(negedge clk);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[3:0] == 0, r[15:8], r[7:5] == 0, r[23:16], r[11:9] == 0,
                r[24], r[27:26] != 0, r[24] ? "R6" : "R5");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule